// File: doc/BRIEF.md
# Four-Bit ECC Correction Sequencer

This block drives the correction phase of a page read protected by a four-error-per-sector BCH-style syndrome engine. It starts from the ten check bytes stored with a 512-byte sector. It unpacks them into eight 10-bit words and feeds those words to the engine. If the engine reports a nonzero syndrome, it runs the engine's error-location step. It then fixes the located bytes in a sector buffer by read-modify-write.

A page whose stored check bytes are all 0xFF is an erased page, and the block skips it. The engine's status field shows a false "complete" code right after location is started. For this reason the sequencer first waits for a busy code, with a bounded wait, and only then polls for the final result. The outcome is one done pulse. It comes with the number of bytes that were actually fixed and a flag marking the sector as uncorrectable.

The syndrome and root-search arithmetic sit outside the block. The block works through the engine's load, clear, start, status and error-register ports.

Top module: `ecc4_fix_seq`

## Requirements
- R1: If all ten bytes of `ecc_bytes` are 0xFF when `start` is accepted, no word is loaded, `done` is high in the cycle right after the accepting edge, and `fixed_cnt` = 0 and `uncorrectable` = 0.
- R2: Byte j of `ecc_bytes` occupies bits [8j+7:8j]. Word k is bits [10k+9:10k] of that 80-bit vector. The eight words are presented on `eng_load_data` with `eng_load_valid` in eight consecutive cycles, word 7 first and word 0 last.
- R3: If `eng_syndrome` is all zero after the loads, the sequence ends with `done` 10 cycles after the accepting edge, with `fixed_cnt` = 0 and `uncorrectable` = 0. Neither `eng_clr` nor `eng_calc_start` pulses.
- R4: On a nonzero syndrome, `eng_clr` pulses for one cycle, and `eng_calc_start` pulses in the cycle right after it.
- R5: After `eng_calc_start`, status codes below 4 are ignored until a code of 4 or more is seen, or until WAIT_LIMIT cycles have passed.
- R6: While polling, status 0 ends with `fixed_cnt` = 0 and `uncorrectable` = 0, and status 1 ends with `uncorrectable` = 1 and `fixed_cnt` = 0. Status 2 or 3 starts correction, and status 4 or more keeps polling.
- R7: The number of errors handled is 1 + `eng_err_cnt`, so there are at most four.
- R8: Errors 0 and 1 use register pair A (`eng_pos_a`, `eng_mag_a`), and errors 2 and 3 use pair B. An even error takes bits [9:0] of the position and bits [7:0] of the value. An odd error takes bits [25:16] and [23:16].
- R9: A position p gives byte offset 519 − p. The byte at that offset is read and written back XOR the error value only when 8 ≤ p ≤ 519. Other positions leave the buffer untouched and are not counted.
- R10: `done` is high for exactly one cycle, and `fixed_cnt` equals the number of bytes rewritten in the sequence. `done` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| ecc_bytes | input | 80 | Ten stored check bytes, byte 0 in bits [7:0] |
| eng_load_valid | output | 1 | A check word is presented to the engine |
| eng_load_data | output | 10 | Check word to load |
| eng_clr | output | 1 | Clear stale error-location results |
| eng_calc_start | output | 1 | Start error-location calculation |
| eng_syndrome | input | 80 | Four syndrome words from the engine |
| eng_state | input | 4 | Engine status code |
| eng_err_cnt | input | 2 | Error count minus one |
| eng_pos_a | input | 32 | Error positions 0 (low half) and 1 (high half) |
| eng_mag_a | input | 32 | Error values 0 (low half) and 1 (high half) |
| eng_pos_b | input | 32 | Error positions 2 (low half) and 3 (high half) |
| eng_mag_b | input | 32 | Error values 2 (low half) and 3 (high half) |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read; data returns the next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write |
| buf_wdata | output | 8 | Corrected byte |
| done | output | 1 | One-cycle completion pulse |
| fixed_cnt | output | 3 | Bytes corrected, valid with done |
| uncorrectable | output | 1 | Sector has too many errors, valid with done |

## Verification
Latency is counted in rising edges from the edge that accepts `start`. For an erased page, `done` is due at once after that edge (0 edges). For a clean syndrome it is due 10 edges later: 8 loads, one settle cycle and one decision cycle. The bench samples at falling edges and checks these exact counts. The timeout case checks that `done` comes no earlier than WAIT_LIMIT edges. Cases that depend on the engine's status are checked when the pulse arrives, and each check then confirms that `done` has dropped one cycle later. The stub engine returns zero error registers until its busy phase ends, so a sequencer that trusts the early "complete" code corrects nothing and is caught.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SYNW, S_SYNC, S_CLR, S_CALC, S_ENTER, S_POLL, S_FRD, S_FWR
  } seq_st_t;
  localparam logic [3:0] ST_NOERR = 4'd0;
  localparam logic [3:0] ST_FAIL  = 4'd1;
  localparam logic [3:0] ST_BUSY  = 4'd4;
endpackage

// File: rtl/ecc4_unpack.sv
module ecc4_unpack #(
  parameter int NBYTES = 10,
  parameter int NVAL   = 8,
  parameter int VW     = 10
) (
  input  logic [NBYTES*8-1:0] bytes_i,
  output logic [NVAL*VW-1:0]  words_o,
  output logic                erased_o
);
  localparam int NB = NBYTES * 8;
  logic [NBYTES-1:0] byte_ff;

  // words are consecutive little-endian bit fields of the byte stream
  for (genvar k = 0; k < NVAL; k++) begin : g_word
    if ((k + 1) * VW <= NB) begin : g_in
      assign words_o[k*VW +: VW] = bytes_i[k*VW +: VW];
    end else begin : g_pad
      assign words_o[k*VW +: VW] = '0;
    end
  end

  for (genvar j = 0; j < NBYTES; j++) begin : g_ff
    assign byte_ff[j] = &bytes_i[j*8 +: 8];
  end

  assign erased_o = &byte_ff;
endmodule

// File: rtl/ecc4_err_pick.sv
module ecc4_err_pick #(
  parameter int REG_W     = 32,
  parameter int VW        = 10,
  parameter int SEC_BYTES = 512,
  parameter int OFF_BASE  = 519
) (
  input  logic [1:0]                     idx_i,
  input  logic [REG_W-1:0]               pos_a_i,
  input  logic [REG_W-1:0]               mag_a_i,
  input  logic [REG_W-1:0]               pos_b_i,
  input  logic [REG_W-1:0]               mag_b_i,
  output logic [$clog2(SEC_BYTES)-1:0]   off_o,
  output logic [7:0]                     mag_o,
  output logic                           ok_o
);
  localparam int HW = REG_W / 2;
  localparam int BW = $clog2(SEC_BYTES);
  localparam int DW = VW + 2;
  localparam int LO = OFF_BASE - SEC_BYTES + 1;

  logic [REG_W-1:0] pos_w, mag_w;
  logic [HW-1:0]    pos_h, mag_h;
  logic [VW-1:0]    pos;
  logic [DW-1:0]    diff;

  always_comb begin
    pos_w = idx_i[1] ? pos_b_i : pos_a_i;
    mag_w = idx_i[1] ? mag_b_i : mag_a_i;
    pos_h = idx_i[0] ? pos_w[REG_W-1:HW] : pos_w[HW-1:0];
    mag_h = idx_i[0] ? mag_w[REG_W-1:HW] : mag_w[HW-1:0];
    pos   = pos_h[VW-1:0];
    mag_o = mag_h[7:0];
    diff  = DW'(OFF_BASE) - DW'(pos);
    off_o = diff[BW-1:0];
    ok_o  = (DW'(pos) >= DW'(LO)) && (DW'(pos) <= DW'(OFF_BASE));
  end
endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_pkg::*;
#(
  parameter int NBYTES     = 10,
  parameter int NVAL       = 8,
  parameter int VW         = 10,
  parameter int SYN_W      = 80,
  parameter int REG_W      = 32,
  parameter int SEC_BYTES  = 512,
  parameter int OFF_BASE   = 519,
  parameter int WAIT_LIMIT = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NBYTES*8-1:0]          ecc_bytes,
  output logic                         eng_load_valid,
  output logic [VW-1:0]                eng_load_data,
  output logic                         eng_clr,
  output logic                         eng_calc_start,
  input  logic [SYN_W-1:0]             eng_syndrome,
  input  logic [3:0]                   eng_state,
  input  logic [1:0]                   eng_err_cnt,
  input  logic [REG_W-1:0]             eng_pos_a,
  input  logic [REG_W-1:0]             eng_mag_a,
  input  logic [REG_W-1:0]             eng_pos_b,
  input  logic [REG_W-1:0]             eng_mag_b,
  output logic [$clog2(SEC_BYTES)-1:0] buf_addr,
  output logic                         buf_rd_en,
  input  logic [7:0]                   buf_rdata,
  output logic                         buf_wr_en,
  output logic [7:0]                   buf_wdata,
  output logic                         done,
  output logic [2:0]                   fixed_cnt,
  output logic                         uncorrectable
);
  localparam int BW  = $clog2(SEC_BYTES);
  localparam int IW  = $clog2(NVAL);
  localparam int WCW = $clog2(WAIT_LIMIT + 1);

  seq_st_t               st;
  logic [NBYTES*8-1:0]   bytes_q;
  logic [NVAL*VW-1:0]    words;
  logic                  erased_in;
  logic                  erased_unused;
  logic [NVAL*VW-1:0]    words_unused;
  logic [IW-1:0]         ld_idx;
  logic [WCW-1:0]        wait_cnt;
  logic [2:0]            n_err, e_idx;
  logic [BW-1:0]         pick_off, fix_off;
  logic [7:0]            pick_mag, fix_mag;
  logic                  pick_ok;

  // erased test on the live input, words from the captured copy
  ecc4_unpack #(.NBYTES(NBYTES), .NVAL(NVAL), .VW(VW)) u_unp_in (
    .bytes_i(ecc_bytes), .words_o(words_unused), .erased_o(erased_in));
  ecc4_unpack #(.NBYTES(NBYTES), .NVAL(NVAL), .VW(VW)) u_unp_q (
    .bytes_i(bytes_q), .words_o(words), .erased_o(erased_unused));

  ecc4_err_pick #(.REG_W(REG_W), .VW(VW), .SEC_BYTES(SEC_BYTES),
                  .OFF_BASE(OFF_BASE)) u_pick (
    .idx_i(e_idx[1:0]), .pos_a_i(eng_pos_a), .mag_a_i(eng_mag_a),
    .pos_b_i(eng_pos_b), .mag_b_i(eng_mag_b),
    .off_o(pick_off), .mag_o(pick_mag), .ok_o(pick_ok));

  always_comb begin
    eng_load_valid = (st == S_LOAD);
    eng_load_data  = words[ld_idx*VW +: VW];
    eng_clr        = (st == S_CLR);
    eng_calc_start = (st == S_CALC);
    buf_rd_en      = (st == S_FRD) && (e_idx != n_err) && pick_ok;
    buf_wr_en      = (st == S_FWR);
    buf_addr       = (st == S_FWR) ? fix_off : pick_off;
    buf_wdata      = buf_rdata ^ fix_mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      bytes_q       <= '0;
      ld_idx        <= '0;
      wait_cnt      <= '0;
      n_err         <= '0;
      e_idx         <= '0;
      fix_off       <= '0;
      fix_mag       <= '0;
      done          <= 1'b0;
      fixed_cnt     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          bytes_q       <= ecc_bytes;
          ld_idx        <= IW'(NVAL - 1);
          fixed_cnt     <= '0;
          uncorrectable <= 1'b0;
          if (erased_in) done <= 1'b1;
          else           st   <= S_LOAD;
        end
        S_LOAD: begin
          if (ld_idx == '0) st <= S_SYNW;
          else              ld_idx <= ld_idx - 1'b1;
        end
        S_SYNW: st <= S_SYNC;
        S_SYNC: begin
          if (eng_syndrome == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_CLR;
          end
        end
        S_CLR: st <= S_CALC;
        S_CALC: begin
          wait_cnt <= '0;
          st       <= S_ENTER;
        end
        S_ENTER: begin
          wait_cnt <= wait_cnt + 1'b1;
          if (eng_state >= ST_BUSY || wait_cnt == WCW'(WAIT_LIMIT - 1))
            st <= S_POLL;
        end
        S_POLL: begin
          if (eng_state == ST_NOERR) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (eng_state == ST_FAIL) begin
            uncorrectable <= 1'b1;
            done          <= 1'b1;
            st            <= S_IDLE;
          end else if (eng_state < ST_BUSY) begin
            n_err <= 3'd1 + {1'b0, eng_err_cnt};
            e_idx <= '0;
            st    <= S_FRD;
          end
        end
        S_FRD: begin
          if (e_idx == n_err) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (pick_ok) begin
            fix_off <= pick_off;
            fix_mag <= pick_mag;
            st      <= S_FWR;
          end else begin
            e_idx <= e_idx + 1'b1;
          end
        end
        S_FWR: begin
          fixed_cnt <= fixed_cnt + 1'b1;
          e_idx     <= e_idx + 1'b1;
          st        <= S_FRD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc4_fix_seq_chk.sv
module ecc4_fix_seq_chk #(
  parameter int BW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          eng_clr,
  input logic          eng_calc_start,
  input logic          buf_rd_en,
  input logic          buf_wr_en,
  input logic [BW-1:0] buf_addr,
  input logic          done,
  input logic [2:0]    fixed_cnt,
  input logic          uncorrectable
);
  a_r4_clr_then_calc: assert property (@(posedge clk) disable iff (rst)
    eng_calc_start |-> $past(eng_clr));
  a_r4_clr_single: assert property (@(posedge clk) disable iff (rst)
    eng_clr |=> !eng_clr);
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> $past(buf_rd_en));
  a_r9_write_same_byte: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> buf_addr == $past(buf_addr));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_fail_no_fix: assert property (@(posedge clk) disable iff (rst)
    (done && uncorrectable) |-> fixed_cnt == 3'd0);
  a_r7_count_max: assert property (@(posedge clk) disable iff (rst)
    done |-> fixed_cnt <= 3'd4);
endmodule

bind ecc4_fix_seq ecc4_fix_seq_chk #(.BW($clog2(SEC_BYTES))) chk_i (
  .clk(clk), .rst(rst), .eng_clr(eng_clr), .eng_calc_start(eng_calc_start),
  .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
  .done(done), .fixed_cnt(fixed_cnt), .uncorrectable(uncorrectable));

// File: tb/ecc4_fix_seq_tb_top.sv
module ecc4_fix_seq_tb_top;
  localparam int WL = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [79:0] ecc_bytes = '0;
  logic        eng_load_valid, eng_clr, eng_calc_start;
  logic [9:0]  eng_load_data;
  logic [79:0] eng_syndrome = '0;
  logic [3:0]  eng_state;
  logic [1:0]  eng_err_cnt;
  logic [31:0] eng_pos_a, eng_mag_a, eng_pos_b, eng_mag_b;
  logic [8:0]  buf_addr;
  logic        buf_rd_en, buf_wr_en;
  logic [7:0]  buf_rdata, buf_wdata;
  logic        done, uncorrectable;
  logic [2:0]  fixed_cnt;

  always #10 clk = ~clk;

  ecc4_fix_seq #(.WAIT_LIMIT(WL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .ecc_bytes(ecc_bytes),
    .eng_load_valid(eng_load_valid), .eng_load_data(eng_load_data),
    .eng_clr(eng_clr), .eng_calc_start(eng_calc_start),
    .eng_syndrome(eng_syndrome), .eng_state(eng_state),
    .eng_err_cnt(eng_err_cnt), .eng_pos_a(eng_pos_a), .eng_mag_a(eng_mag_a),
    .eng_pos_b(eng_pos_b), .eng_mag_b(eng_mag_b), .buf_addr(buf_addr),
    .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
    .buf_wdata(buf_wdata), .done(done), .fixed_cnt(fixed_cnt),
    .uncorrectable(uncorrectable));

  // sector buffer, one-cycle read latency
  logic [7:0] mem [512];
  always @(posedge clk) begin
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
  end

  // stub engine: configuration set by tasks
  int          cfg_busy = 4;
  logic [3:0]  cfg_final = 4'd2;
  logic [1:0]  cfg_cnt = 2'd0;
  logic [31:0] cfg_pa = '0, cfg_ma = '0, cfg_pb = '0, cfg_mb = '0;

  logic [9:0] ld_buf [8];
  int ld_n = 0, ph = 0, clr_n = 0, calc_n = 0;
  logic clr_ok = 1'b1;
  always @(posedge clk) begin
    if (start) begin
      ld_n <= 0; ph <= 0; clr_n <= 0; calc_n <= 0; clr_ok <= 1'b1;
    end else begin
      if (eng_load_valid) begin
        if (ld_n < 8) ld_buf[ld_n] <= eng_load_data;
        ld_n <= ld_n + 1;
      end
      if (eng_clr) clr_n <= clr_n + 1;
      if (eng_calc_start) begin
        calc_n <= calc_n + 1;
        if (clr_n == 0) clr_ok <= 1'b0;
        ph <= 1;
      end else if (ph != 0 && ph < 1000) ph <= ph + 1;
    end
  end
  wire fin = (ph > 3 + cfg_busy);
  assign eng_state   = (ph == 0) ? 4'd0 : (ph <= 3) ? 4'd3 : !fin ? 4'd5 : cfg_final;
  assign eng_err_cnt = fin ? cfg_cnt : 2'd0;
  assign eng_pos_a   = fin ? cfg_pa : '0;
  assign eng_mag_a   = fin ? cfg_ma : '0;
  assign eng_pos_b   = fin ? cfg_pb : '0;
  assign eng_mag_b   = fin ? cfg_mb : '0;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_b(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 512; i++) mem[i] = init_b(i);
  endtask

  // run a sequence; returns latency in edges after the accepting edge
  task automatic run(input logic [79:0] b, output int lat, output int cnt, output bit unc);
    @(negedge clk);
    ecc_bytes = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    cnt = int'(fixed_cnt);
    unc = uncorrectable;
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
  endtask

  function automatic logic [9:0] word_of(input logic [79:0] b, input int k);
    logic [9:0] w;
    for (int t = 0; t < 10; t++) w[t] = b[(10 * k + t) / 8 * 8 + (10 * k + t) % 8];
    return w;
  endfunction

  task automatic t_reset();
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    chk(!eng_load_valid && !buf_wr_en, "R10 reset idle", int'(eng_load_valid), 0);
  endtask

  task automatic t_erased();
    int lat, cnt; bit unc;
    run({10{8'hFF}}, lat, cnt, unc);
    chk(lat == 0, "R1 erased latency", lat, 0);
    chk(cnt == 0 && !unc, "R1 erased result", cnt, 0);
    chk(ld_n == 0, "R1 no loads", ld_n, 0);
  endtask

  task automatic t_clean();
    int lat, cnt; bit unc;
    logic [79:0] b = 80'h3A_C5_91_0F_7E_D2_48_B6_1C_E3;
    eng_syndrome = '0;
    run(b, lat, cnt, unc);
    chk(ld_n == 8, "R2 load count", ld_n, 8);
    for (int k = 0; k < 8; k++)
      chk(ld_buf[k] == word_of(b, 7 - k), "R2 load order", int'(ld_buf[k]), int'(word_of(b, 7 - k)));
    chk(lat == 10, "R3 clean latency", lat, 10);
    chk(cnt == 0 && !unc, "R3 clean result", cnt, 0);
    chk(clr_n == 0 && calc_n == 0, "R3 no calc", clr_n + calc_n, 0);
  endtask

  task automatic t_final(input logic [3:0] fs, input bit exp_unc);
    int lat, cnt; bit unc;
    eng_syndrome = 80'h1;
    cfg_final = fs; cfg_busy = 4; cfg_cnt = 2'd0;
    run(80'h0123_4567_89AB_CDEF_0011, lat, cnt, unc);
    chk(clr_n == 1 && calc_n == 1 && clr_ok, "R4 clear then start", clr_n, 1);
    chk(unc == exp_unc, "R6 uncorrectable flag", int'(unc), int'(exp_unc));
    chk(cnt == 0, "R6 no fixes", cnt, 0);
  endtask

  task automatic t_fix4();
    int lat, cnt; bit unc;
    fill_mem();
    eng_syndrome = 80'h40;
    cfg_final = 4'd3; cfg_busy = 6; cfg_cnt = 2'd3;
    // e0 pos 519 -> off 0, e1 pos 8 -> off 511, e2 pos 600 out, e3 pos 300 -> off 219
    cfg_pa = {16'd8, 16'd519};   cfg_ma = {16'h00A5, 16'h003C};
    cfg_pb = {16'd300, 16'd600}; cfg_mb = {16'h0081, 16'h00FF};
    run(80'h5, lat, cnt, unc);
    chk(cnt == 3 && !unc, "R9 fixed count", cnt, 3);
    chk(mem[0] == (init_b(0) ^ 8'h3C), "R8 error 0 pair A low", int'(mem[0]), int'(init_b(0) ^ 8'h3C));
    chk(mem[511] == (init_b(511) ^ 8'hA5), "R8 error 1 pair A high", int'(mem[511]), int'(init_b(511) ^ 8'hA5));
    chk(mem[219] == (init_b(219) ^ 8'h81), "R8 error 3 pair B high", int'(mem[219]), int'(init_b(219) ^ 8'h81));
    chk(mem[1] == init_b(1) && mem[218] == init_b(218), "R9 neighbours kept", int'(mem[1]), int'(init_b(1)));
    chk(lat > 3 + 6, "R5 waited past busy", lat, 10);
  endtask

  task automatic t_fix1();
    int lat, cnt; bit unc;
    fill_mem();
    eng_syndrome = 80'h2;
    cfg_final = 4'd2; cfg_busy = 2; cfg_cnt = 2'd0;
    cfg_pa = {16'd100, 16'd500}; cfg_ma = {16'h0077, 16'h0011};
    cfg_pb = {16'd200, 16'd300}; cfg_mb = {16'h0022, 16'h0033};
    run(80'h9, lat, cnt, unc);
    chk(cnt == 1, "R7 single error", cnt, 1);
    chk(mem[19] == (init_b(19) ^ 8'h11), "R7 first fix", int'(mem[19]), int'(init_b(19) ^ 8'h11));
    chk(mem[419] == init_b(419) && mem[219] == init_b(219), "R7 extra pairs ignored", int'(mem[419]), int'(init_b(419)));
  endtask

  task automatic t_timeout();
    int lat, cnt; bit unc;
    fill_mem();
    eng_syndrome = 80'h8;
    cfg_final = 4'd2; cfg_busy = -1; cfg_cnt = 2'd0;
    cfg_pa = {16'd0, 16'd7}; cfg_ma = {16'h0, 16'h0055};
    run(80'h7, lat, cnt, unc);
    chk(lat >= WL, "R5 wait timeout", lat, WL);
    chk(cnt == 0 && !unc, "R9 position 7 skipped", cnt, 0);
    chk(mem[0] == init_b(0), "R9 buffer untouched", int'(mem[0]), int'(init_b(0)));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    fill_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_erased();
    t_clean();
    t_final(4'd0, 1'b0);
    t_final(4'd1, 1'b1);
    t_fix4();
    t_fix1();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule